// File: doc/BRIEF.md
# Multi-View FIFO Communication Cell

This block is one inter-thread communication cell that works as a small hardware FIFO. Software reaches the cell through a set of access views. Each view gives the same storage a different meaning. The views are:

- raw peek and patch of the storage;
- reading and loading the cell's status word;
- push and pop with a blocking flavour;
- push and pop with a non-blocking flavour.

Two semaphore view codes also exist. In this FIFO-mode cell they are inert.

Every access carries a view code, a read/write flag, write data and a requester ID. An access that would have to wait returns a "blocked" response and has no other effect. In that case the cell records the requester in a waiter bitmask. The next push or pop on either empty/full view that does not block releases every recorded waiter: the cell pulses a wake output that carries the mask, then clears the mask. Halting and restarting the requesters is the job of the logic around the cell.

Requests arrive on a valid/ready channel and responses leave on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle. `req_ready` is low only while an earlier response is still held because the consumer has not taken it. The response then stays frozen until `resp_ready` is seen high. The wake output is a plain one-cycle strobe and has no back-pressure.

Top module: `xview_fifo_cell`

## Requirements
- R1: After reset the storage, head index and occupancy are zero, the waiter mask is empty, and no response or wake is pending. A status read returns 0x3002_0001: empty=1, fifo=1, and the depth field set to log2 of the depth, which is 3 for a depth of 8.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. Exactly one response follows in the next cycle, for reads and for writes. While `resp_valid` is high and `resp_ready` is low, `req_ready` is low and the response data and blocked flag stay unchanged.
- R3: A read on view 1 (status) returns a word with these fields: empty at bit 0, full at bit 1, trigger at bit 16, fifo-mode (always 1) at bit 17, occupancy from bit 18, and the depth field from bit 28. All other bits are zero.
- R4: A write on view 1 loads trigger, empty and full from data bits 16, 0 and 1. If the loaded empty bit is 1, the occupancy becomes zero.
- R5: A read on view 3 (non-blocking pop) clears the full bit. If occupancy is non-zero, it returns the head entry and pops it, so entries leave in push order; otherwise it returns 0. Whenever occupancy is then zero, the empty bit is set.
- R6: A write on view 3 (non-blocking push) clears the empty bit. If occupancy is below the depth, it stores the data at head plus occupancy (modulo depth); a push to a full cell is dropped. Whenever occupancy then equals the depth, the full bit is set.
- R7: A read on view 2 (blocking pop) while the empty bit is set returns blocked=1 with data 0. It sets bit `req_id` of the waiter mask, clears the full bit, and leaves the data, head and occupancy untouched. Otherwise it behaves as R5.
- R8: A write on view 2 (blocking push) while the full bit is set returns blocked=1 with data 0. It sets bit `req_id` of the waiter mask, clears the empty bit, and stores nothing. Otherwise it behaves as R6.
- R9: An access on view 2 or 3 that does not block, made while the waiter mask is non-empty, pulses `wake_valid` for exactly one cycle in the response cycle. `wake_mask` then carries the mask as it stood before the access, and the mask is cleared.
- R10: A read on view 0 (raw) returns the entry at the head index and changes no state.
- R11: A write on view 0 overwrites the most recently pushed entry, at head plus occupancy minus one, when occupancy is non-zero. When the cell is empty it has no effect.
- R12: Views 4 and 5 (semaphore views) return 0 on read and change no state on write.
- R13: View codes 6 to 15 return all ones on read and change no state on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cell can take a request |
| req_view | input | 4 | View code 0..15 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (32) | Write data |
| req_id | input | log2(IDS) (6) | Requester number |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | DW (32) | Read data (0 for writes and blocked accesses) |
| resp_blocked | output | 1 | Access blocked; requester recorded |
| wake_valid | output | 1 | One-cycle waiter release strobe |
| wake_mask | output | IDS (64) | Requesters released by this strobe |

## Verification
The bench aims at the corner cases where the pointers and flags do not match the occupancy.

- A ninth push into a full cell must be dropped. A design that wraps the write slot would overwrite the head entry.
- A pop from an empty cell must return 0. A design that still pops would push occupancy below zero.
- A status write that clears empty on an empty cell leaves empty=0 with occupancy 0. The next pop must then set empty again.
- A blocked access must record its requester without moving the pointers. A release must carry every waiter recorded since the last release. A design that wakes on a blocked access, or forgets to clear the mask, shows a wrong `wake_mask` or a repeated strobe.
- A raw write on an empty cell must change nothing. An off-by-one in the newest-entry slot corrupts the entry that was pushed earlier.

A long pseudo-random sequence over all sixteen view codes is checked, access by access, against an arithmetic model of the cell.

// File: rtl/xcell_pkg.sv
package xcell_pkg;

  typedef enum logic [3:0] {
    VW_RAW     = 4'd0,
    VW_TAG     = 4'd1,
    VW_EF_WAIT = 4'd2,
    VW_EF_POLL = 4'd3,
    VW_PV_WAIT = 4'd4,
    VW_PV_POLL = 4'd5
  } view_e;

  // status word field positions (decoded by software)
  localparam int unsigned BIT_EMPTY = 0;
  localparam int unsigned BIT_FULL  = 1;
  localparam int unsigned BIT_TRIG  = 16;
  localparam int unsigned BIT_MODE  = 17;
  localparam int unsigned LSB_OCC   = 18;
  localparam int unsigned LSB_DEPTH = 28;
  localparam int unsigned DEPTH_FLD_W = 4;

endpackage

// File: rtl/xcell_store.sv
module xcell_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/xcell_engine.sv
module xcell_engine
  import xcell_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDS   = 64,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned OW   = IW + 1,
  localparam int unsigned RW   = $clog2(IDS)
) (
  // decoded access
  input  logic [3:0]    view,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] rid,
  // current state
  input  logic          e_q,
  input  logic          f_q,
  input  logic          t_q,
  input  logic [IW-1:0] head_q,
  input  logic [OW-1:0] occ_q,
  input  logic [IDS-1:0] mask_q,
  input  logic [DW-1:0] head_data,
  // next state
  output logic          e_d,
  output logic          f_d,
  output logic          t_d,
  output logic [IW-1:0] head_d,
  output logic [OW-1:0] occ_d,
  output logic [IDS-1:0] mask_d,
  // storage write
  output logic          st_we,
  output logic [IW-1:0] st_idx,
  // response
  output logic [DW-1:0] rdata,
  output logic          blocked,
  output logic          wake
);

  logic          sync_view;
  logic          ef_view;
  logic          release_w;
  logic [DW-1:0] status_word;

  assign ef_view   = (view == VW_EF_WAIT) || (view == VW_EF_POLL);
  assign sync_view = (view == VW_EF_WAIT);

  always_comb begin
    status_word = '0;
    status_word[BIT_EMPTY] = e_q;
    status_word[BIT_FULL]  = f_q;
    status_word[BIT_TRIG]  = t_q;
    status_word[BIT_MODE]  = 1'b1;
    status_word[LSB_OCC +: OW] = occ_q;
    status_word[LSB_DEPTH +: DEPTH_FLD_W] = DEPTH_FLD_W'(IW);
  end

  always_comb begin
    e_d       = e_q;
    f_d       = f_q;
    t_d       = t_q;
    head_d    = head_q;
    occ_d     = occ_q;
    st_we     = 1'b0;
    st_idx    = head_q + occ_q[IW-1:0];
    rdata     = '0;
    blocked   = 1'b0;
    release_w = 1'b0;

    unique case (view)
      VW_RAW: begin
        if (write) begin
          if (occ_q != '0) begin
            st_we  = 1'b1;
            st_idx = head_q + occ_q[IW-1:0] - IW'(1);
          end
        end else begin
          rdata = head_data;
        end
      end

      VW_TAG: begin
        if (write) begin
          e_d = wdata[BIT_EMPTY];
          f_d = wdata[BIT_FULL];
          t_d = wdata[BIT_TRIG];
          if (wdata[BIT_EMPTY]) begin
            occ_d = '0;
          end
        end else begin
          rdata = status_word;
        end
      end

      VW_EF_WAIT, VW_EF_POLL: begin
        if (!write) begin
          f_d = 1'b0;
          if (sync_view && e_q) begin
            blocked = 1'b1;
          end else begin
            release_w = 1'b1;
            if (occ_q != '0) begin
              rdata  = head_data;
              head_d = head_q + IW'(1);
              occ_d  = occ_q - OW'(1);
            end
            if (occ_d == '0) begin
              e_d = 1'b1;
            end
          end
        end else begin
          e_d = 1'b0;
          if (sync_view && f_q) begin
            blocked = 1'b1;
          end else begin
            release_w = 1'b1;
            if (occ_q < OW'(DEPTH)) begin
              st_we = 1'b1;
              occ_d = occ_q + OW'(1);
            end
            if (occ_d == OW'(DEPTH)) begin
              f_d = 1'b1;
            end
          end
        end
      end

      VW_PV_WAIT, VW_PV_POLL: begin
        rdata = '0;
      end

      default: begin
        if (!write) begin
          rdata = '1;
        end
      end
    endcase
  end

  always_comb begin
    mask_d = mask_q;
    if (blocked) begin
      mask_d = mask_q | (IDS'(1) << rid);
    end else if (ef_view && release_w) begin
      mask_d = '0;
    end
  end

  assign wake = release_w && (mask_q != '0);

endmodule

// File: rtl/xview_fifo_cell.sv
module xview_fifo_cell #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDS   = 64,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned OW   = IW + 1,
  localparam int unsigned RW   = $clog2(IDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_view,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  input  logic [RW-1:0]  req_id,
  output logic           resp_valid,
  input  logic           resp_ready,
  output logic [DW-1:0]  resp_data,
  output logic           resp_blocked,
  output logic           wake_valid,
  output logic [IDS-1:0] wake_mask
);

  logic           e_q, f_q, t_q;
  logic           e_d, f_d, t_d;
  logic [IW-1:0]  head_q, head_d;
  logic [OW-1:0]  occ_q, occ_d;
  logic [IDS-1:0] mask_q, mask_d;
  logic           st_we;
  logic [IW-1:0]  st_idx;
  logic [DW-1:0]  head_data;
  logic [DW-1:0]  rdata;
  logic           blocked;
  logic           wake;
  logic           take;

  assign req_ready = !resp_valid || resp_ready;
  assign take      = req_valid && req_ready;

  xcell_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take && st_we),
    .wr_idx  (st_idx),
    .wr_data (req_wdata),
    .rd_idx  (head_q),
    .rd_data (head_data)
  );

  xcell_engine #(.DW(DW), .DEPTH(DEPTH), .IDS(IDS)) u_engine (
    .view      (req_view),
    .write     (req_write),
    .wdata     (req_wdata),
    .rid       (req_id),
    .e_q       (e_q),
    .f_q       (f_q),
    .t_q       (t_q),
    .head_q    (head_q),
    .occ_q     (occ_q),
    .mask_q    (mask_q),
    .head_data (head_data),
    .e_d       (e_d),
    .f_d       (f_d),
    .t_d       (t_d),
    .head_d    (head_d),
    .occ_d     (occ_d),
    .mask_d    (mask_d),
    .st_we     (st_we),
    .st_idx    (st_idx),
    .rdata     (rdata),
    .blocked   (blocked),
    .wake      (wake)
  );

  // cell state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q    <= 1'b1;
      f_q    <= 1'b0;
      t_q    <= 1'b0;
      head_q <= '0;
      occ_q  <= '0;
      mask_q <= '0;
    end else if (take) begin
      e_q    <= e_d;
      f_q    <= f_d;
      t_q    <= t_d;
      head_q <= head_d;
      occ_q  <= occ_d;
      mask_q <= mask_d;
    end
  end

  // response slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_data    <= '0;
      resp_blocked <= 1'b0;
    end else if (take) begin
      resp_valid   <= 1'b1;
      resp_data    <= rdata;
      resp_blocked <= blocked;
    end else if (resp_ready) begin
      resp_valid   <= 1'b0;
    end
  end

  // waiter release strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= take && wake;
      wake_mask  <= (take && wake) ? mask_q : '0;
    end
  end

endmodule

// File: rtl/xcell_chk.sv
module xcell_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDS   = 64,
  localparam int unsigned OW   = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [3:0]     req_view,
  input logic           req_write,
  input logic [DW-1:0]  req_wdata,
  input logic           resp_valid,
  input logic           resp_ready,
  input logic [DW-1:0]  resp_data,
  input logic           resp_blocked,
  input logic           wake_valid,
  input logic [IDS-1:0] wake_mask,
  input logic [OW-1:0]  occ
);

  // R2
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_blocked));

  // R9
  wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> wake_mask != '0);

  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid);

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));

  // R4
  tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && req_view == 4'd1 && req_wdata[0] |=> occ == '0);

  // R7
  blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_blocked |-> resp_data == '0);

  // R13
  bad_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_view >= 4'd6 |=> resp_data == '1 && !resp_blocked);

endmodule

bind xview_fifo_cell xcell_chk #(.DW(DW), .DEPTH(DEPTH), .IDS(IDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_view     (req_view),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_data    (resp_data),
  .resp_blocked (resp_blocked),
  .wake_valid   (wake_valid),
  .wake_mask    (wake_mask),
  .occ          (occ_q)
);

// File: tb/xview_fifo_cell_tb.sv
module xview_fifo_cell_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_view = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [5:0]  req_id = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [31:0] resp_data;
  logic        resp_blocked;
  logic        wake_valid;
  logic [63:0] wake_mask;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  xview_fifo_cell u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_view(req_view), .req_write(req_write),
    .req_wdata(req_wdata), .req_id(req_id),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_blocked(resp_blocked),
    .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  // reference model of the cell
  logic [31:0] m_dat [8];
  int          m_head = 0;
  int          m_occ = 0;
  bit          m_e = 1'b1, m_f = 1'b0, m_t = 1'b0;
  logic [63:0] m_mask = '0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic string tag_of(input int v, input bit w, input bit blk);
    case (v)
      0: return w ? "R11" : "R10";
      1: return w ? "R4" : "R3";
      2, 3: return blk ? (w ? "R8" : "R7") : (w ? "R6" : "R5");
      4, 5: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic acc(input int v, input bit w, input logic [31:0] d, input int id);
    logic [31:0] x_data;
    bit          x_blk;
    bit          x_wake;
    logic [63:0] x_wmask;
    bit          sy;
    x_data = 32'h0; x_blk = 1'b0; x_wake = 1'b0; x_wmask = '0;
    sy = (v == 2);
    case (v)
      0: begin
        if (w) begin
          if (m_occ > 0) m_dat[(m_head + m_occ - 1) % 8] = d;
        end else x_data = m_dat[m_head];
      end
      1: begin
        if (w) begin
          m_t = d[16]; m_e = d[0]; m_f = d[1];
          if (m_e) m_occ = 0;
        end else begin
          x_data = 32'(m_e) | (32'(m_f) << 1) | (32'(m_t) << 16) | (32'd1 << 17)
                 | (32'(m_occ) << 18) | (32'd3 << 28);
        end
      end
      2, 3: begin
        if (!w) begin
          m_f = 1'b0;
          if (sy && m_e) begin
            x_blk = 1'b1; m_mask[id] = 1'b1;
          end else begin
            x_wake = (m_mask != 0); x_wmask = m_mask; m_mask = '0;
            if (m_occ > 0) begin
              x_data = m_dat[m_head]; m_head = (m_head + 1) % 8; m_occ--;
            end
            if (m_occ == 0) m_e = 1'b1;
          end
        end else begin
          m_e = 1'b0;
          if (sy && m_f) begin
            x_blk = 1'b1; m_mask[id] = 1'b1;
          end else begin
            x_wake = (m_mask != 0); x_wmask = m_mask; m_mask = '0;
            if (m_occ < 8) begin
              m_dat[(m_head + m_occ) % 8] = d; m_occ++;
            end
            if (m_occ == 8) m_f = 1'b1;
          end
        end
      end
      4, 5: x_data = 32'h0;
      default: x_data = w ? 32'h0 : 32'hFFFF_FFFF;
    endcase

    @(negedge clk);
    req_valid = 1'b1; req_view = 4'(v); req_write = w; req_wdata = d; req_id = 6'(id);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid === 1'b1, "R2 resp_valid", 64'(resp_valid), 64'd1);
    chk(resp_data === x_data && resp_blocked === x_blk, tag_of(v, w, x_blk),
        {31'd0, resp_blocked, resp_data}, {31'd0, x_blk, x_data});
    chk(wake_valid === x_wake && (!x_wake || wake_mask === x_wmask), "R9 wake",
        wake_valid ? wake_mask : 64'd0, x_wake ? x_wmask : 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 8; i++) m_dat[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(resp_valid === 1'b0 && wake_valid === 1'b0 && req_ready === 1'b1, "R1 idle",
        {61'd0, resp_valid, wake_valid, req_ready}, 64'd1);
    acc(1, 0, 0, 0);
    chk(resp_data === 32'h3002_0001, "R1 status", 64'(resp_data), 64'h3002_0001);

    // R6 fill past depth, R3 status while full
    for (int i = 0; i < 9; i++) acc(3, 1, 32'hA000_0000 + 32'(i), 1);
    acc(1, 0, 0, 0);
    acc(2, 1, 32'h55, 63);            // R8 blocked push
    acc(0, 0, 0, 0);                  // R10 peek head
    acc(0, 1, 32'hBEEF, 0);           // R11 patch newest
    for (int i = 0; i < 4; i++) acc(4 + (i % 2), i % 2, 32'h7, 2); // R12
    acc(1, 0, 0, 0);
    for (int v = 6; v < 16; v++) begin // R13
      acc(v, 1, 32'h1234, 3);
      acc(v, 0, 0, 3);
    end
    acc(1, 0, 0, 0);
    // R5 drain with wake release for waiter 63
    for (int i = 0; i < 10; i++) acc(3, 0, 0, 4);
    acc(0, 1, 32'hDEAD, 0);           // R11 ignored when empty
    acc(0, 0, 0, 0);
    // R7 blocked pops then release
    acc(2, 0, 0, 5);
    acc(2, 0, 0, 40);
    acc(1, 0, 0, 0);
    acc(3, 1, 32'h77, 9);             // R9 wake bits 5 and 40
    acc(2, 0, 0, 6);                  // pops 0x77
    // R4 clear empty on an empty cell then pop
    acc(1, 1, 32'h0001_0000, 0);
    acc(1, 0, 0, 0);
    acc(3, 0, 0, 0);
    acc(1, 0, 0, 0);
    acc(1, 1, 32'h0000_0002, 0);      // full flag without data
    acc(2, 1, 32'h99, 11);            // R8 blocks on flag
    acc(1, 0, 0, 0);

    // R2 back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_view = 4'd1; req_write = 1'b0; req_id = '0;
    @(negedge clk);
    req_valid = 1'b0;
    lf = resp_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(resp_valid === 1'b1 && req_ready === 1'b0 && resp_data === lf, "R2 stall",
          {62'd0, resp_valid, req_ready}, 64'd2);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    chk(resp_valid === 1'b0 && req_ready === 1'b1, "R2 drain",
        {62'd0, resp_valid, req_ready}, 64'd1);

    // pseudo-random sweep against the model
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      int v;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      v = (lf[3:0] < 4'd13) ? int'(lf[6:4]) % 6 : int'(lf[11:8]);
      if (v == 1 && lf[14]) v = 3;
      acc(v, lf[12], {lf[31:20], 3'b0, lf[16], 14'd0, lf[19:18]}, int'(lf[27:22]));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule